// File: doc/BRIEF.md
# Structure Load Deinterleave Unit

This block turns a run of bytes fetched from memory into the contents of up to four 128-bit vector registers. The bytes hold a stream of structures, each made of N equal-sized elements, where N is 1 to 4. The unit sends every element to its own register, so that after a load each register holds one field of the structure across its lanes. An interleaved pixel stream is one example: it comes out as one register per colour channel.

There are three ways to load. A full load fills every lane. A replicate load reads a single structure and copies each of its elements into all lanes of its register. A lane load reads a single structure and writes it into one chosen lane of each register, and the other lanes keep their values.

Each operation starts with a one-cycle pulse on `start`. It also returns the number of bytes consumed and the updated, post-indexed address pointer. Input bytes are taken as little-endian. Register r occupies bits `[r*128 +: 128]` of the register buses. Byte b of register r sits at bits `[(r*16+b)*8 +: 8]`. Byte i of the buffer sits at bits `[i*8 +: 8]`.

Top module: `struct_load_unit`

## Requirements
- R1: When `nregs_m1`=0 and the mode is full, buffer bytes 0..15 go to register 0 bytes 0..15 in order.
- R2: `esize` selects the element width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. A register holds 16/width lanes, and an element keeps its byte order inside its lane.
- R3: In full mode (`mode`=0, and the unused code 3 acts the same), element k of the buffer goes to register k mod N, lane k div N, where N = `nregs_m1`+1.
- R4: With N=3 and byte elements, a 48-byte R,G,B stream puts all red bytes in register 0, all green bytes in register 1 and all blue bytes in register 2.
- R5: In replicate mode (`mode`=1), element r of the structure at buffer offset 0 fills every lane of register r, for each r < N.
- R6: In lane mode (`mode`=2), element r of the structure at buffer offset 0 is written into the selected lane of register r, for each r < N. All other lanes keep their `regs_in` values.
- R7: `bytes_used` is N*16 in full mode and N*width in the other two modes. With `post_mode`=1, `ptr_out` = `ptr_in` + `bytes_used`.
- R8: With `post_mode`=2, `ptr_out` = `ptr_in` + `stride`. With `post_mode`=0 or 3, `ptr_out` = `ptr_in`.
- R9: `done` is high for exactly the one cycle after a `start` cycle, and all outputs are valid while it is high. Outputs hold their values until the next start.
- R10: The lane index is masked to the lane count (lane_idx AND (lanes-1)). Registers N..3 are always returned equal to `regs_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle operation request |
| mem_bytes | input | 512 | Bytes read from memory, byte 0 in the low bits |
| nregs_m1 | input | 2 | Structure element count minus one |
| esize | input | 2 | Element width code |
| mode | input | 2 | 0 full, 1 replicate, 2 lane, 3 full |
| lane_idx | input | 4 | Target lane for lane mode |
| regs_in | input | 512 | Current contents of the four registers |
| ptr_in | input | 32 | Address pointer before the access |
| post_mode | input | 2 | 0 none, 1 immediate, 2 stride, 3 none |
| stride | input | 32 | Register-supplied pointer increment |
| done | output | 1 | Result valid pulse |
| regs_out | output | 512 | Updated register contents |
| bytes_used | output | 7 | Bytes transferred |
| ptr_out | output | 32 | Post-indexed pointer |

## Verification
The bench builds the block with its default parameters: four registers of 16 bytes and a 32-bit pointer. With these values the full 64-byte buffer is reachable, as are all four element widths and every structure count from 1 to 4. The lane index covers all 16 byte lanes, so a lane index too large for wider elements can be applied and the masking checked. Operations use both the immediate and the stride pointer update, and some set structure counts below four, which shows that the upper registers are left untouched.

// File: rtl/sld_pkg.sv
package sld_pkg;

  typedef enum logic [1:0] {
    LD_FULL = 2'd0,
    LD_REPL = 2'd1,
    LD_LANE = 2'd2,
    LD_ALT  = 2'd3
  } ld_mode_e;

  typedef enum logic [1:0] {
    PI_NONE = 2'd0,
    PI_IMM  = 2'd1,
    PI_REG  = 2'd2,
    PI_ALT  = 2'd3
  } post_e;

  // Source byte in the memory buffer for output byte b of register r.
  function automatic int src_byte(ld_mode_e m, int n, int esz, int r, int b);
    int off;
    off = b & ((1 << esz) - 1);
    if (m == LD_REPL || m == LD_LANE) return (r << esz) + off;
    return ((((b >> esz) * n) + r) << esz) + off;
  endfunction

  // Whether output byte b of register r takes fresh data.
  function automatic bit takes_new(ld_mode_e m, int n, int esz, int lane, int r, int b);
    if (r >= n) return 1'b0;
    if (m == LD_LANE) return ((b >> esz) == lane);
    return 1'b1;
  endfunction

  function automatic int xfer_count(ld_mode_e m, int n, int esz, int vec_bytes);
    if (m == LD_REPL || m == LD_LANE) return n << esz;
    return n * vec_bytes;
  endfunction

endpackage

// File: rtl/sld_decode.sv
module sld_decode
  import sld_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  parameter int NUM_REGS  = 4,
  parameter int RSEL_W    = 2,
  parameter int NCNT_W    = 3,
  parameter int LANE_W    = 4,
  parameter int CNT_W     = 7
) (
  input  logic [RSEL_W-1:0] nregs_m1,
  input  logic [1:0]        esz,
  input  ld_mode_e          mode,
  input  logic [LANE_W-1:0] lane_idx,
  output logic [NCNT_W-1:0] n_regs,
  output logic [LANE_W-1:0] lane_sel,
  output logic [CNT_W-1:0]  xfer
);
  logic [LANE_W-1:0] lanes_m1;

  always_comb begin
    n_regs   = NCNT_W'(nregs_m1) + NCNT_W'(1);
    lanes_m1 = LANE_W'((VEC_BYTES >> esz) - 1);
    lane_sel = lane_idx & lanes_m1;
    xfer     = CNT_W'(xfer_count(mode, int'(n_regs), int'(esz), VEC_BYTES));
  end
endmodule

// File: rtl/sld_byte_router.sv
module sld_byte_router
  import sld_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  parameter int NUM_REGS  = 4,
  parameter int NCNT_W    = 3,
  parameter int LANE_W    = 4
) (
  input  ld_mode_e                        mode,
  input  logic [NCNT_W-1:0]               n_regs,
  input  logic [1:0]                      esz,
  input  logic [LANE_W-1:0]               lane_sel,
  input  logic [NUM_REGS*VEC_BYTES*8-1:0] mem,
  input  logic [NUM_REGS*VEC_BYTES*8-1:0] old_regs,
  output logic [NUM_REGS*VEC_BYTES*8-1:0] new_regs
);
  localparam int MEM_BYTES = NUM_REGS * VEC_BYTES;
  localparam int IDX_W     = $clog2(MEM_BYTES);

  logic [7:0] mem_arr [MEM_BYTES];

  for (genvar i = 0; i < MEM_BYTES; i++) begin : g_unpack
    assign mem_arr[i] = mem[i*8 +: 8];
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
      logic [IDX_W-1:0] src;
      logic             take;
      always_comb begin
        src  = IDX_W'(src_byte(mode, int'(n_regs), int'(esz), r, b));
        take = takes_new(mode, int'(n_regs), int'(esz), int'(lane_sel), r, b);
      end
      assign new_regs[(r*VEC_BYTES+b)*8 +: 8] =
        take ? mem_arr[src] : old_regs[(r*VEC_BYTES+b)*8 +: 8];
    end
  end
endmodule

// File: rtl/sld_ptr_calc.sv
module sld_ptr_calc
  import sld_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 7
) (
  input  post_e             post,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [CNT_W-1:0]  xfer,
  output logic [ADDR_W-1:0] next_ptr
);
  always_comb begin
    unique case (post)
      PI_IMM:  next_ptr = ptr + ADDR_W'(xfer);
      PI_REG:  next_ptr = ptr + stride;
      default: next_ptr = ptr;
    endcase
  end
endmodule

// File: rtl/struct_load_unit.sv
module struct_load_unit
  import sld_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  parameter int NUM_REGS  = 4,
  parameter int ADDR_W    = 32,
  localparam int MEM_BYTES = NUM_REGS * VEC_BYTES,
  localparam int BUS_W     = MEM_BYTES * 8,
  localparam int RSEL_W    = $clog2(NUM_REGS),
  localparam int NCNT_W    = $clog2(NUM_REGS + 1),
  localparam int LANE_W    = $clog2(VEC_BYTES),
  localparam int CNT_W     = $clog2(MEM_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUS_W-1:0]  mem_bytes,
  input  logic [RSEL_W-1:0] nregs_m1,
  input  logic [1:0]        esize,
  input  logic [1:0]        mode,
  input  logic [LANE_W-1:0] lane_idx,
  input  logic [BUS_W-1:0]  regs_in,
  input  logic [ADDR_W-1:0] ptr_in,
  input  logic [1:0]        post_mode,
  input  logic [ADDR_W-1:0] stride,
  output logic              done,
  output logic [BUS_W-1:0]  regs_out,
  output logic [CNT_W-1:0]  bytes_used,
  output logic [ADDR_W-1:0] ptr_out
);
  // Named internal events for the assertions.
  logic              launch;
  logic [NCNT_W-1:0] n_regs;
  logic [LANE_W-1:0] lane_sel;
  logic [CNT_W-1:0]  xfer;
  logic [BUS_W-1:0]  routed;
  logic [ADDR_W-1:0] next_ptr;
  ld_mode_e          mode_e;
  post_e             post_e_v;

  assign launch   = start;
  assign mode_e   = ld_mode_e'(mode);
  assign post_e_v = post_e'(post_mode);

  sld_decode #(
    .VEC_BYTES(VEC_BYTES), .NUM_REGS(NUM_REGS), .RSEL_W(RSEL_W),
    .NCNT_W(NCNT_W), .LANE_W(LANE_W), .CNT_W(CNT_W)
  ) u_decode (
    .nregs_m1(nregs_m1), .esz(esize), .mode(mode_e), .lane_idx(lane_idx),
    .n_regs(n_regs), .lane_sel(lane_sel), .xfer(xfer)
  );

  sld_byte_router #(
    .VEC_BYTES(VEC_BYTES), .NUM_REGS(NUM_REGS), .NCNT_W(NCNT_W), .LANE_W(LANE_W)
  ) u_router (
    .mode(mode_e), .n_regs(n_regs), .esz(esize), .lane_sel(lane_sel),
    .mem(mem_bytes), .old_regs(regs_in), .new_regs(routed)
  );

  sld_ptr_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
    .post(post_e_v), .ptr(ptr_in), .stride(stride), .xfer(xfer), .next_ptr(next_ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      regs_out   <= '0;
      bytes_used <= '0;
      ptr_out    <= '0;
    end else begin
      done <= launch;
      if (launch) begin
        regs_out   <= routed;
        bytes_used <= xfer;
        ptr_out    <= next_ptr;
      end
    end
  end

  // R9: result pulse follows the request by one cycle
  p_done_follows_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> done);
  p_done_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(launch));
  // R7: byte count is within the buffer and never zero
  p_xfer_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bytes_used != '0 && int'(bytes_used) <= MEM_BYTES));
  // R8: no post-index keeps the pointer
  p_ptr_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ($past(post_mode) == 2'd0)) |-> ptr_out == $past(ptr_in));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_keep_chk
    // R10: registers above the structure count are passed through
    p_upper_regs_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (r > int'($past(nregs_m1)))) |->
        regs_out[r*VEC_BYTES*8 +: VEC_BYTES*8] == $past(regs_in[r*VEC_BYTES*8 +: VEC_BYTES*8]));
  end
endmodule

// File: tb/struct_load_unit_test.sv
module struct_load_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int MB = 64;
  localparam int BW = MB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [BW-1:0] mem_bytes = '0;
  logic [1:0]    nregs_m1 = '0;
  logic [1:0]    esize = '0;
  logic [1:0]    mode = '0;
  logic [3:0]    lane_idx = '0;
  logic [BW-1:0] regs_in = '0;
  logic [31:0]   ptr_in = '0;
  logic [1:0]    post_mode = '0;
  logic [31:0]   stride = '0;
  logic          done;
  logic [BW-1:0] regs_out;
  logic [6:0]    bytes_used;
  logic [31:0]   ptr_out;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [BW-1:0] exp_regs_q [$];
  int            exp_bytes_q [$];
  logic [31:0]   exp_ptr_q [$];
  string         tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  struct_load_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_bytes(mem_bytes),
    .nregs_m1(nregs_m1), .esize(esize), .mode(mode), .lane_idx(lane_idx),
    .regs_in(regs_in), .ptr_in(ptr_in), .post_mode(post_mode), .stride(stride),
    .done(done), .regs_out(regs_out), .bytes_used(bytes_used), .ptr_out(ptr_out)
  );

  task automatic chk(bit ok, string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: builds the expected result from the stream model and issues the op.
  task automatic run_op(string tag, int n, int esz, int md, int lane, int post,
                        logic [31:0] ptr, logic [31:0] strd, int seed);
    logic [BW-1:0] mem, old, exp;
    int eb, lanes, lsel, nbytes;
    logic [31:0] eptr;
    eb = 1 << esz;
    lanes = 16 / eb;
    for (int i = 0; i < MB; i++) begin
      mem[i*8 +: 8] = 8'(seed + i * 3);
      old[i*8 +: 8] = 8'(8'hC0 ^ i);
    end
    exp = old;
    if (md == 1) begin
      for (int r = 0; r < n; r++)
        for (int l = 0; l < lanes; l++)
          for (int o = 0; o < eb; o++)
            exp[(r*16 + l*eb + o)*8 +: 8] = mem[(r*eb + o)*8 +: 8];
      nbytes = n * eb;
    end else if (md == 2) begin
      lsel = lane % lanes;
      for (int r = 0; r < n; r++)
        for (int o = 0; o < eb; o++)
          exp[(r*16 + lsel*eb + o)*8 +: 8] = mem[(r*eb + o)*8 +: 8];
      nbytes = n * eb;
    end else begin
      for (int k = 0; k < n * lanes; k++)
        for (int o = 0; o < eb; o++)
          exp[((k % n)*16 + (k / n)*eb + o)*8 +: 8] = mem[(k*eb + o)*8 +: 8];
      nbytes = n * 16;
    end
    if (post == 1) eptr = ptr + 32'(nbytes);
    else if (post == 2) eptr = ptr + strd;
    else eptr = ptr;
    exp_regs_q.push_back(exp);
    exp_bytes_q.push_back(nbytes);
    exp_ptr_q.push_back(eptr);
    tag_q.push_back(tag);

    @(negedge clk);
    mem_bytes = mem; regs_in = old; nregs_m1 = 2'(n - 1); esize = 2'(esz);
    mode = 2'(md); lane_idx = 4'(lane); post_mode = 2'(post); ptr_in = ptr; stride = strd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, {"R9 done high ", tag}, BW'(done), BW'(1));
    @(negedge clk);
    chk(done == 1'b0, {"R9 done one cycle ", tag}, BW'(done), BW'(0));
  endtask

  // Monitor: compares results against the queued expectations.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_regs_q.size() == 0) begin
        chk(1'b0, "R9 unexpected done", BW'(1), BW'(0));
      end else begin
        logic [BW-1:0] er;
        int eby;
        logic [31:0] ep;
        string t;
        er = exp_regs_q.pop_front();
        eby = exp_bytes_q.pop_front();
        ep = exp_ptr_q.pop_front();
        t = tag_q.pop_front();
        chk(regs_out == er, {t, " regs"}, regs_out, er);
        chk(int'(bytes_used) == eby, {"R7 bytes ", t}, BW'(bytes_used), BW'(eby));
        chk(ptr_out == ep, {t, " ptr"}, BW'(ptr_out), BW'(ep));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && regs_out == '0 && ptr_out == '0, "R9 reset state",
        regs_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op("R1 single reg bytes",       1, 0, 0, 0, 1, 32'h1000, 0, 5);
    run_op("R3 pairs halfword",         2, 1, 0, 0, 1, 32'h2000, 0, 17);
    run_op("R4 rgb bytes",              3, 0, 0, 0, 1, 32'h3000, 0, 40);
    run_op("R2 quad words",             4, 2, 0, 0, 0, 32'h4000, 0, 9);
    run_op("R7 pairs doubleword",       2, 3, 0, 0, 1, 32'h5000, 0, 77);
    run_op("R3 alt mode code",          3, 1, 3, 0, 3, 32'h5800, 0, 61);
    run_op("R5 replicate bytes",        3, 0, 1, 0, 1, 32'h6000, 0, 3);
    run_op("R5 replicate doubleword",   4, 3, 1, 0, 2, 32'h7000, 32'h140, 21);
    run_op("R6 lane insert",            3, 0, 2, 4, 1, 32'h8000, 0, 90);
    run_op("R10 lane masked",           2, 1, 2, 13, 1, 32'h9000, 0, 33);
    run_op("R8 stride post",            1, 2, 0, 0, 2, 32'hA000, 32'hFFFF_FFF0, 12);
    run_op("R10 single word lane",      1, 2, 2, 7, 0, 32'hB000, 0, 50);
    repeat (3) @(negedge clk);
    chk(exp_regs_q.size() == 0, "R9 all results seen", BW'(exp_regs_q.size()), '0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired actual=hang expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule